// File: doc/BRIEF.md
# Audio Sample-Rate Mode Detector

This block watches the three clocks of a serial audio input: the frame clock, the master clock and the bit clock. From them it decides which of three speed classes the stream belongs to. It times the frame-clock period with a free-running reference clock and places the result in one of three separate frequency bands. Rates that fall in the gaps between the bands, or outside all of them, are reported as unsupported.

In the master-clock domain it counts master-clock cycles per frame and passes that count to the reference domain. There it is matched against the recognised oversampling ratios. A speed class is declared only when three conditions hold together: three consecutive period measurements agree, the ratio is one the class accepts, and all three clocks are toggling. A downstream converter uses the mode and valid outputs to pick its filter and timing settings.

Top module: `srate_mode_detect`

## Requirements
- R1: While the synchronous active-high reset is held, and right after it, `mode_o`, `valid_o`, `unsupported_o` and `ratio_o` are all 0.
- R2: A frame rate from 30 kHz to 54 kHz with an accepted ratio gives `mode_o` = 1 (single speed). The mode encoding is 0 none, 1 single, 2 double, 3 quad.
- R3: A frame rate from 84 kHz to 108 kHz with an accepted ratio gives `mode_o` = 2 (double speed).
- R4: A frame rate from 170 kHz to 216 kHz with an accepted ratio gives `mode_o` = 3 (quad speed).
- R5: A frame rate outside all three bands gives `unsupported_o` = 1, with `mode_o` = 0 and `valid_o` = 0.
- R6: `ratio_o` gives the master-clock cycles per frame as a code: 1=128, 2=192, 3=256, 4=384, 5=512, 6=768, 7=1024. A count within ±2 of a nominal ratio takes that ratio's code. Any other count gives 0.
- R7: Single speed accepts codes 3..7, double speed accepts codes 1..5 and quad speed accepts codes 1..3. A ratio outside the set for the band keeps `valid_o` and `mode_o` at 0, while `ratio_o` still reports the code.
- R8: When the master clock stops for longer than the activity timeout, `valid_o`, `mode_o` and `ratio_o` fall to 0.
- R9: When the bit clock stops for longer than the activity timeout, `valid_o` and `mode_o` fall to 0.
- R10: When the frame clock stops, all four outputs fall to 0. When it resumes, the first partial period is discarded and detection returns.
- R11: A new band is committed only after three consecutive period measurements fall in it. After two, the previous mode is still shown.
- R12: `valid_o` is 1 exactly when `mode_o` is non-zero, and it is never 1 together with `unsupported_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, frequency REF_HZ |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| mclk_i | input | 1 | Master clock |
| sclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Frame clock; its frequency is the sample rate |
| mode_o | output | 2 | 0 none, 1 single, 2 double, 3 quad speed |
| valid_o | output | 1 | A qualified mode is present |
| unsupported_o | output | 1 | The committed frame rate lies in no band |
| ratio_o | output | 3 | Detected master-clock-to-frame ratio code |

## Verification
The bench steps the frame rate through points inside each band and through each dead zone, including both the low and the high side. This separates correct band edges from bands that are too wide or merged. At fixed rates it changes the ratio through accepted values, values the band refuses, and counts two and three cycles away from a nominal ratio. These cases separate the ratio tolerance from the per-band acceptance sets. It then gates each clock off in turn to see which outputs drop, and it switches the band at a frame boundary to count how many measurements the commit takes.

// File: rtl/srm_pkg.sv
`timescale 1ns/1ps
package srm_pkg;

  typedef enum logic [2:0] {
    BAND_NONE   = 3'd0,
    BAND_SINGLE = 3'd1,
    BAND_DOUBLE = 3'd2,
    BAND_QUAD   = 3'd3,
    BAND_OUT    = 3'd4
  } band_t;

  localparam int NUM_RATIOS = 7;

  // nominal master-clock cycles per frame for ratio code idx (1..7)
  function automatic int ratio_of(input int idx);
    case (idx)
      1:       ratio_of = 128;
      2:       ratio_of = 192;
      3:       ratio_of = 256;
      4:       ratio_of = 384;
      5:       ratio_of = 512;
      6:       ratio_of = 768;
      7:       ratio_of = 1024;
      default: ratio_of = 0;
    endcase
  endfunction

  // which ratio codes each speed band tolerates
  function automatic logic ratio_allowed(input band_t b, input logic [2:0] code);
    case (b)
      BAND_SINGLE: ratio_allowed = (code >= 3'd3);
      BAND_DOUBLE: ratio_allowed = (code >= 3'd1) && (code <= 3'd5);
      BAND_QUAD:   ratio_allowed = (code >= 3'd1) && (code <= 3'd3);
      default:     ratio_allowed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/srm_sync.sv
`timescale 1ns/1ps
module srm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/srm_mclk_counter.sv
`timescale 1ns/1ps
module srm_mclk_counter #(
  parameter int CNT_W = 12
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic             lrck,
  output logic [CNT_W-1:0] count_o,
  output logic             toggle_o,
  output logic             beat_o
);

  logic             rst_m;
  logic             lrck_m;
  logic             lrck_q;
  logic             rise;
  logic [CNT_W-1:0] run_cnt;
  logic [1:0]       div;

  // reset brought into the master-clock domain
  srm_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(mclk), .rst(1'b0), .d(rst), .q(rst_m)
  );

  srm_sync #(.W(1), .STAGES(2)) u_lrck_sync (
    .clk(mclk), .rst(rst_m), .d(lrck), .q(lrck_m)
  );

  assign rise = lrck_m & ~lrck_q;

  always_ff @(posedge mclk) begin
    if (rst_m) begin
      lrck_q   <= 1'b0;
      run_cnt  <= '0;
      count_o  <= '0;
      toggle_o <= 1'b0;
      div      <= '0;
    end else begin
      lrck_q <= lrck_m;
      div    <= div + 2'd1;
      if (rise) begin
        count_o  <= run_cnt;
        toggle_o <= ~toggle_o;
        run_cnt  <= CNT_W'(1);
      end else if (run_cnt != '1) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // slow heartbeat of the master clock, safe to sample in the reference domain
  assign beat_o = div[1];

endmodule

// File: rtl/srm_ratio_decode.sv
`timescale 1ns/1ps
module srm_ratio_decode
  import srm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOL   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             toggle_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [2:0]       code_o
);

  logic                  tgl_s;
  logic                  tgl_q;
  logic                  snap_new;
  logic [CNT_W-1:0]      snap;
  logic [NUM_RATIOS-1:0] hit;
  logic [2:0]            code_n;

  srm_sync #(.W(1), .STAGES(2)) u_tgl_sync (
    .clk(clk), .rst(rst), .d(toggle_i), .q(tgl_s)
  );

  // the count is held stable for a whole frame after each toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q    <= 1'b0;
      snap_new <= 1'b0;
      snap     <= '0;
    end else begin
      tgl_q    <= tgl_s;
      snap_new <= tgl_s ^ tgl_q;
      if (tgl_s ^ tgl_q) snap <= count_i;
    end
  end

  for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_win
    localparam int NOM = ratio_of(k + 1);
    assign hit[k] = (int'(snap) >= NOM - TOL) && (int'(snap) <= NOM + TOL);
  end

  always_comb begin
    code_n = 3'd0;
    for (int k = 0; k < NUM_RATIOS; k++) begin
      if (hit[k]) code_n = 3'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           code_o <= 3'd0;
    else if (snap_new) code_o <= code_n;
  end

  // R6
  win_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

endmodule

// File: rtl/srm_activity.sv
`timescale 1ns/1ps
module srm_activity #(
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic active_o
);

  localparam int CW = $clog2(TIMEOUT + 1);

  logic          prev;
  logic [CW-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= 1'b0;
      idle     <= '0;
      active_o <= 1'b0;
    end else begin
      prev <= sig;
      if (sig != prev) begin
        idle     <= '0;
        active_o <= 1'b1;
      end else if (idle == CW'(TIMEOUT - 1)) begin
        active_o <= 1'b0;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end

  // R8
  idle_cap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(idle) < TIMEOUT);

endmodule

// File: rtl/srm_band_tracker.sv
`timescale 1ns/1ps
module srm_band_tracker
  import srm_pkg::*;
#(
  parameter int REF_HZ    = 50_000_000,
  parameter int SS_MIN_HZ = 30_000,
  parameter int SS_MAX_HZ = 54_000,
  parameter int DS_MIN_HZ = 84_000,
  parameter int DS_MAX_HZ = 108_000,
  parameter int QS_MIN_HZ = 170_000,
  parameter int QS_MAX_HZ = 216_000,
  parameter int TIMEOUT   = 2083,
  parameter int HYST      = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  lrck_s,
  output band_t band_o
);

  // period limits in reference cycles: faster rate gives the lower bound
  localparam int SS_LO = REF_HZ / SS_MAX_HZ;
  localparam int SS_HI = REF_HZ / SS_MIN_HZ;
  localparam int DS_LO = REF_HZ / DS_MAX_HZ;
  localparam int DS_HI = REF_HZ / DS_MIN_HZ;
  localparam int QS_LO = REF_HZ / QS_MAX_HZ;
  localparam int QS_HI = REF_HZ / QS_MIN_HZ;
  localparam int PW    = $clog2(TIMEOUT + 1);
  localparam int AW    = $clog2(HYST + 1);

  logic          lr_q;
  logic          armed;
  logic          rise;
  logic          meas;
  logic [PW-1:0] per;
  band_t         cls;
  band_t         cand;
  logic [AW-1:0] agree;

  assign rise = lrck_s & ~lr_q;
  assign meas = rise & armed;

  always_comb begin
    if (int'(per) >= SS_LO && int'(per) <= SS_HI)      cls = BAND_SINGLE;
    else if (int'(per) >= DS_LO && int'(per) <= DS_HI) cls = BAND_DOUBLE;
    else if (int'(per) >= QS_LO && int'(per) <= QS_HI) cls = BAND_QUAD;
    else                                               cls = BAND_OUT;
  end

  // period counter; a saturated count disarms until the next clean edge
  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q  <= 1'b0;
      armed <= 1'b0;
      per   <= '0;
    end else begin
      lr_q <= lrck_s;
      if (rise) begin
        per   <= PW'(1);
        armed <= 1'b1;
      end else if (per == PW'(TIMEOUT)) begin
        armed <= 1'b0;
      end else begin
        per <= per + 1'b1;
      end
    end
  end

  // run-length filter over consecutive classifications
  always_ff @(posedge clk) begin
    if (rst) begin
      cand   <= BAND_NONE;
      agree  <= '0;
      band_o <= BAND_NONE;
    end else if (meas) begin
      if (cls == cand) begin
        if (agree != AW'(HYST)) agree <= agree + 1'b1;
        if (int'(agree) + 1 >= HYST) band_o <= cls;
      end else begin
        cand  <= cls;
        agree <= AW'(1);
        if (HYST <= 1) band_o <= cls;
      end
    end
  end

  // R11
  commit_run_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(band_o) |-> ($past(meas) && (int'($past(agree)) + 1 >= HYST)));

endmodule

// File: rtl/srate_mode_detect.sv
`timescale 1ns/1ps
module srate_mode_detect
  import srm_pkg::*;
#(
  parameter int REF_HZ    = 50_000_000,
  parameter int SS_MIN_HZ = 30_000,
  parameter int SS_MAX_HZ = 54_000,
  parameter int DS_MIN_HZ = 84_000,
  parameter int DS_MAX_HZ = 108_000,
  parameter int QS_MIN_HZ = 170_000,
  parameter int QS_MAX_HZ = 216_000,
  parameter int HYST      = 3,
  parameter int TOL       = 2,
  parameter int CNT_W     = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mclk_i,
  input  logic       sclk_i,
  input  logic       lrck_i,
  output logic [1:0] mode_o,
  output logic       valid_o,
  output logic       unsupported_o,
  output logic [2:0] ratio_o
);

  // longest frame period plus a quarter
  localparam int TIMEOUT = (REF_HZ / SS_MIN_HZ) * 5 / 4;
  localparam int IX_LR   = 0;
  localparam int IX_SC   = 1;
  localparam int IX_MC   = 2;

  logic [CNT_W-1:0] m_count;
  logic             m_toggle;
  logic             m_beat;
  logic [2:0]       raw;
  logic [2:0]       synced;
  logic [2:0]       act;
  band_t            band;
  logic [2:0]       code;
  logic             qual;

  srm_mclk_counter #(.CNT_W(CNT_W)) u_mcnt (
    .mclk(mclk_i), .rst(rst), .lrck(lrck_i),
    .count_o(m_count), .toggle_o(m_toggle), .beat_o(m_beat)
  );

  assign raw = {m_beat, sclk_i, lrck_i};

  srm_sync #(.W(3), .STAGES(2)) u_in_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  for (genvar i = 0; i < 3; i++) begin : g_act
    srm_activity #(.TIMEOUT(TIMEOUT)) u_act (
      .clk(clk), .rst(rst), .sig(synced[i]), .active_o(act[i])
    );
  end

  srm_band_tracker #(
    .REF_HZ(REF_HZ),
    .SS_MIN_HZ(SS_MIN_HZ), .SS_MAX_HZ(SS_MAX_HZ),
    .DS_MIN_HZ(DS_MIN_HZ), .DS_MAX_HZ(DS_MAX_HZ),
    .QS_MIN_HZ(QS_MIN_HZ), .QS_MAX_HZ(QS_MAX_HZ),
    .TIMEOUT(TIMEOUT), .HYST(HYST)
  ) u_band (
    .clk(clk), .rst(rst), .lrck_s(synced[IX_LR]), .band_o(band)
  );

  srm_ratio_decode #(.CNT_W(CNT_W), .TOL(TOL)) u_ratio (
    .clk(clk), .rst(rst), .toggle_i(m_toggle), .count_i(m_count), .code_o(code)
  );

  assign qual = (&act) && (band inside {BAND_SINGLE, BAND_DOUBLE, BAND_QUAD})
                && ratio_allowed(band, code);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o        <= 2'd0;
      valid_o       <= 1'b0;
      unsupported_o <= 1'b0;
      ratio_o       <= 3'd0;
    end else begin
      mode_o        <= qual ? band[1:0] : 2'd0;
      valid_o       <= qual;
      unsupported_o <= act[IX_LR] && (band == BAND_OUT);
      ratio_o       <= (act[IX_MC] && act[IX_LR]) ? code : 3'd0;
    end
  end

  // R12
  valid_unsup_excl_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !unsupported_o);

  // R5
  unsup_no_mode_chk: assert property (@(posedge clk) disable iff (rst)
    unsupported_o |-> (mode_o == 2'd0));

  // R7
  valid_has_ratio_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (ratio_o != 3'd0));

  // R8
  clocks_gate_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(&act) |=> !valid_o);

endmodule

// File: tb/tb_srate_mode_detect.sv
`timescale 1ns/1ps
module tb_srate_mode_detect;

  localparam int REF_HZ = 100_000_000;
  localparam int TO     = (REF_HZ / 30_000) * 5 / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic mclk_gen = 1'b0, sclk_gen = 1'b0, lrck_gen = 1'b0;
  logic mclk_en = 1'b1, sclk_en = 1'b1, lrck_en = 1'b1;
  logic mclk_pin, sclk_pin, lrck_pin;
  assign mclk_pin = mclk_gen & mclk_en;
  assign sclk_pin = sclk_gen & sclk_en;
  assign lrck_pin = lrck_gen & lrck_en;

  logic [1:0] mode_o;
  logic       valid_o, unsupported_o;
  logic [2:0] ratio_o;

  srate_mode_detect #(.REF_HZ(REF_HZ)) dut (
    .clk(clk), .rst(rst), .mclk_i(mclk_pin), .sclk_i(sclk_pin), .lrck_i(lrck_pin),
    .mode_o(mode_o), .valid_o(valid_o), .unsupported_o(unsupported_o), .ratio_o(ratio_o)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  real cfg_hp    = 1.0e9 / (2.0 * 48000.0 * 256.0);
  int  cfg_ratio = 256;
  int  cfg_id    = 0;
  real gen_hp;
  int  gen_r;
  int  frame_id  = 0;

  // frame clock derived from master-clock edges; settings change at frame start
  initial begin
    forever begin
      gen_hp   = cfg_hp;
      gen_r    = cfg_ratio;
      frame_id = cfg_id;
      lrck_gen = 1'b1;
      for (int i = 0; i < gen_r; i++) begin
        if (i == gen_r / 2) lrck_gen = 1'b0;
        #(gen_hp);
        mclk_gen = 1'b1;
        sclk_gen = ~sclk_gen;
        #(gen_hp);
        mclk_gen = 1'b0;
      end
    end
  end

  task automatic set_cfg(input int fs, input int r);
    cfg_ratio = r;
    cfg_hp    = 1.0e9 / (2.0 * real'(fs) * real'(r));
    cfg_id    = cfg_id + 1;
  endtask

  function automatic int exp_band(input int fs);
    if (fs >= 30000 && fs <= 54000)   return 1;
    if (fs >= 84000 && fs <= 108000)  return 2;
    if (fs >= 170000 && fs <= 216000) return 3;
    return 4;
  endfunction

  function automatic int exp_code(input int r);
    int noms[7];
    noms = '{128, 192, 256, 384, 512, 768, 1024};
    for (int k = 0; k < 7; k++) begin
      if (r >= noms[k] - 2 && r <= noms[k] + 2) return k + 1;
    end
    return 0;
  endfunction

  function automatic bit exp_ok(input int b, input int c);
    case (b)
      1: return c >= 3 && c <= 7;
      2: return c >= 1 && c <= 5;
      3: return c >= 1 && c <= 3;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic sync_new_frame();
    @(posedge lrck_gen);
    while (frame_id != cfg_id) @(posedge lrck_gen);
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(input int fs, input int r, input string tag);
    int b, c, ev, em, eu;
    set_cfg(fs, r);
    sync_new_frame();
    repeat (3) @(posedge lrck_gen);
    settle();
    b  = exp_band(fs);
    c  = exp_code(r);
    ev = (b >= 1 && b <= 3 && exp_ok(b, c)) ? 1 : 0;
    em = ev ? b : 0;
    eu = (b == 4) ? 1 : 0;
    check(tag, "mode", int'(mode_o), em);
    check(tag, "valid", int'(valid_o), ev);
    check(tag, "unsupported", int'(unsupported_o), eu);
    check("R6", "ratio", int'(ratio_o), c);
    check("R12", "valid vs mode", int'(valid_o), int'(mode_o != 2'd0));
  endtask

  initial begin
    repeat (12) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared under reset
    check("R1", "mode", int'(mode_o), 0);
    check("R1", "valid", int'(valid_o), 0);
    check("R1", "unsupported", int'(unsupported_o), 0);
    check("R1", "ratio", int'(ratio_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "valid after release", int'(valid_o), 0);

    run_case(48000, 256, "R2");

    // R11: two new measurements keep the old mode, the third commits
    set_cfg(96000, 256);
    sync_new_frame();
    repeat (2) @(posedge lrck_gen);
    settle();
    check("R11", "mode after two", int'(mode_o), 1);
    @(posedge lrck_gen);
    settle();
    check("R11", "mode after three", int'(mode_o), 2);

    run_case(48000, 1024, "R2");
    run_case(48000, 128, "R7");
    run_case(32000, 512, "R2");
    run_case(96000, 128, "R3");
    run_case(96000, 512, "R3");
    run_case(96000, 768, "R7");
    run_case(88200, 192, "R3");
    run_case(96000, 258, "R6");
    run_case(96000, 259, "R6");
    run_case(96000, 300, "R6");
    run_case(192000, 128, "R4");
    run_case(192000, 256, "R4");
    run_case(192000, 384, "R7");
    run_case(176400, 192, "R4");
    run_case(60000, 256, "R5");
    run_case(150000, 128, "R5");
    run_case(25000, 256, "R5");

    // R8: master clock removed
    run_case(192000, 256, "R4");
    mclk_en = 1'b0;
    repeat (TO + 200) @(posedge clk);
    @(negedge clk);
    check("R8", "valid", int'(valid_o), 0);
    check("R8", "mode", int'(mode_o), 0);
    check("R8", "ratio", int'(ratio_o), 0);
    mclk_en = 1'b1;

    // R9: bit clock removed
    run_case(192000, 128, "R4");
    sclk_en = 1'b0;
    repeat (TO + 200) @(posedge clk);
    @(negedge clk);
    check("R9", "valid", int'(valid_o), 0);
    check("R9", "mode", int'(mode_o), 0);
    check("R9", "ratio", int'(ratio_o), 1);
    sclk_en = 1'b1;

    // R10: frame clock removed while an unsupported rate is committed
    run_case(230000, 128, "R5");
    lrck_en = 1'b0;
    repeat (TO + 200) @(posedge clk);
    @(negedge clk);
    check("R10", "unsupported", int'(unsupported_o), 0);
    check("R10", "valid", int'(valid_o), 0);
    check("R10", "mode", int'(mode_o), 0);
    check("R10", "ratio", int'(ratio_o), 0);
    lrck_en = 1'b1;
    run_case(192000, 128, "R10");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule